// File: doc/BRIEF.md
# On-the-fly Row Parity Syndrome Checker

This block works next to the row processing units of a layered LDPC decoder. It verifies the parity-check constraints while the decoder runs, so no separate syndrome pass follows each iteration. A row processing unit finishes a row and raises that lane's completion strobe. It also presents the row's parity: the XOR of the hard decisions of the row's arguments. A hard decision is 1 for a negative posterior LLR and 0 for a zero or positive one. Up to `LANES` rows can complete in one cycle.

The checker counts the completed rows of the current iteration. An iteration holds `BLOCK_ROWS*EXPANSION` rows. Once any row of the iteration shows odd parity, the checker stops verifying rows for the rest of that iteration. When the last row of the iteration has arrived, it gives one of three outcomes:
- every constraint was even, so decoding halts with a valid codeblock;
- a constraint failed, so the next iteration is requested;
- a constraint failed in the last allowed iteration, so the codeblock is given up as invalid.

The final pass/fail verdict stays latched so that it can be validated later. A codeblock begins with a one-cycle `cbStart`.

Top module: `otf_syndrome_checker`

## Requirements
- R1: After reset every output is 0, the block is idle and `iterIndex` is 0.
- R2: A row fails when its parity input is 1 and passes when it is 0. If any row of an iteration fails and the iteration is not the last allowed one, `nextIter` pulses for exactly one cycle, in the cycle after the clock edge that takes in the iteration's final rows. `haltValid` stays 0.
- R3: If all rows of an iteration have even parity, `haltValid` pulses for one cycle, in the cycle after the final rows are taken in. In that cycle `verdictReady` and `verdictPass` go to 1 and `busy` goes to 0.
- R4: After the first failing row of an iteration, the later rows of that iteration cannot change the outcome. Whether their parity is odd or even, the iteration still ends in `nextIter`.
- R5: If only one row fails and it sits in the final batch of the iteration, the iteration still ends in `nextIter` and not in `haltValid`.
- R6: The row count and the failure state clear at the end of every iteration. An all-even iteration that follows a failed one ends in `haltValid`.
- R7: If a row fails in iteration index `MAX_ITER-1` (0-based), `giveUpInvalid` pulses for one cycle instead of `nextIter`. `verdictReady` goes to 1 and `verdictPass` goes to 0.
- R8: `iterIndex` is 0 after `cbStart`. It rises by one with each `nextIter` and holds its value across `haltValid` and `giveUpInvalid`.
- R9: While idle, row strobes have no effect: no outcome pulse, and `verdictPass`, `verdictReady` and `iterIndex` keep their values.
- R10: Rows are counted per asserted lane of `rowDone`, so a cycle may carry a partial batch. The parity bit of a lane whose strobe is 0 is ignored.
- R11: At most one of `haltValid`, `nextIter` and `giveUpInvalid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cbStart | input | 1 | Begin a new codeblock: clears the iteration index and the row state |
| rowDone | input | LANES | One completion strobe per row processing lane |
| rowParity | input | LANES | Parity per lane: 1 means odd, so the row fails |
| haltValid | output | 1 | One-cycle pulse: all constraints even, decoding halts |
| nextIter | output | 1 | One-cycle pulse: a constraint failed, start the next iteration |
| giveUpInvalid | output | 1 | One-cycle pulse: iteration limit reached with a failure |
| verdictPass | output | 1 | Latched final verdict, 1 for valid |
| verdictReady | output | 1 | A verdict has been latched |
| busy | output | 1 | A codeblock is being checked |
| iterIndex | output | IW | 0-based index of the current iteration |

## Verification
The assertions assume that the lanes never deliver more rows than an iteration holds. The count must land exactly on `BLOCK_ROWS*EXPANSION`, and `cbStart` is not raised in the same cycle as row strobes. The bench keeps to these assumptions. It drives whole batches, or partial batches whose lane counts add up exactly to the row total, and it leaves an idle cycle after every `cbStart` before sending rows.

// File: rtl/otf_syn_pkg.sv
package otf_syn_pkg;
  typedef struct packed {
    logic absorb;     // take in this cycle's row strobes
    logic clearRows;  // restart the row count and failure state
    logic clearIter;  // restart the iteration index
    logic bumpIter;   // advance the iteration index
  } synCtrlT;
endpackage

// File: rtl/otf_syn_datapath.sv
module otf_syn_datapath
  import otf_syn_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int ROWS     = 32,
  parameter int MAX_ITER = 4,
  localparam int RW = $clog2(ROWS + 1),
  localparam int IW = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  synCtrlT          ctrl,
  input  logic [LANES-1:0] rowDone,
  input  logic [LANES-1:0] rowParity,
  output logic             lastBatch,
  output logic             iterFail,
  output logic             atLimit,
  output logic [IW-1:0]    iterIdx
);
  logic [RW-1:0] rowsSeen;
  logic [RW:0]   sumRows;
  logic          failSticky;
  logic          checkEn;
  logic          batchFail;

  function automatic logic [RW:0] countLanes(input logic [LANES-1:0] v);
    logic [RW:0] c;
    c = '0;
    for (int i = 0; i < LANES; i++) c = c + (RW+1)'(v[i]);
    return c;
  endfunction

  always_comb begin
    sumRows   = {1'b0, rowsSeen} + countLanes(rowDone);
    lastBatch = ctrl.absorb && (sumRows == (RW+1)'(ROWS));
    checkEn   = ~failSticky;
    batchFail = ctrl.absorb && checkEn && |(rowDone & rowParity);
    iterFail  = failSticky | batchFail;
    atLimit   = (iterIdx == IW'(MAX_ITER - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowsSeen   <= '0;
      failSticky <= 1'b0;
      iterIdx    <= '0;
    end else begin
      if (ctrl.clearRows) begin
        rowsSeen   <= '0;
        failSticky <= 1'b0;
      end else if (ctrl.absorb) begin
        rowsSeen <= sumRows[RW-1:0];
        if (batchFail) failSticky <= 1'b1;
      end
      if (ctrl.clearIter)     iterIdx <= '0;
      else if (ctrl.bumpIter) iterIdx <= iterIdx + 1'b1;
    end
  end

  assert_rows_below_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rowsSeen < RW'(ROWS));

  assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (failSticky && !ctrl.clearRows) |=> failSticky);

  assert_rows_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clearRows |=> (rowsSeen == '0 && !failSticky));
endmodule

// File: rtl/otf_syn_control.sv
module otf_syn_control
  import otf_syn_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cbStart,
  input  logic    lastBatch,
  input  logic    iterFail,
  input  logic    atLimit,
  output synCtrlT ctrl,
  output logic    haltValid,
  output logic    nextIter,
  output logic    giveUpInvalid,
  output logic    verdictPass,
  output logic    verdictReady,
  output logic    busy
);
  typedef enum logic {IDLE, RUN} stateT;
  stateT state;

  always_comb begin
    ctrl.absorb    = (state == RUN) && !cbStart;
    ctrl.clearIter = cbStart;
    ctrl.clearRows = cbStart | lastBatch;
    ctrl.bumpIter  = lastBatch && iterFail && !atLimit;
    busy           = (state == RUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= IDLE;
      haltValid     <= 1'b0;
      nextIter      <= 1'b0;
      giveUpInvalid <= 1'b0;
      verdictPass   <= 1'b0;
      verdictReady  <= 1'b0;
    end else begin
      haltValid     <= 1'b0;
      nextIter      <= 1'b0;
      giveUpInvalid <= 1'b0;
      if (cbStart) begin
        state <= RUN;
      end else if (lastBatch) begin
        if (!iterFail) begin
          haltValid    <= 1'b1;
          verdictPass  <= 1'b1;
          verdictReady <= 1'b1;
          state        <= IDLE;
        end else if (atLimit) begin
          giveUpInvalid <= 1'b1;
          verdictPass   <= 1'b0;
          verdictReady  <= 1'b1;
          state         <= IDLE;
        end else begin
          nextIter <= 1'b1;
        end
      end
    end
  end

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({haltValid, nextIter, giveUpInvalid}));

  assert_halt_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    haltValid |-> (!busy && verdictReady && verdictPass));

  assert_giveup_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    giveUpInvalid |-> (!busy && verdictReady && !verdictPass));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cbStart) |=> !(haltValid || nextIter || giveUpInvalid));
endmodule

// File: rtl/otf_syndrome_checker.sv
module otf_syndrome_checker
  import otf_syn_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int BLOCK_ROWS = 4,
  parameter int EXPANSION  = 8,
  parameter int MAX_ITER   = 4,
  localparam int ROWS = BLOCK_ROWS * EXPANSION,
  localparam int IW   = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbStart,
  input  logic [LANES-1:0] rowDone,
  input  logic [LANES-1:0] rowParity,
  output logic             haltValid,
  output logic             nextIter,
  output logic             giveUpInvalid,
  output logic             verdictPass,
  output logic             verdictReady,
  output logic             busy,
  output logic [IW-1:0]    iterIndex
);
  synCtrlT ctrl;
  logic    lastBatch;
  logic    iterFail;
  logic    atLimit;

  otf_syn_datapath #(.LANES(LANES), .ROWS(ROWS), .MAX_ITER(MAX_ITER)) dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .rowDone(rowDone),
    .rowParity(rowParity), .lastBatch(lastBatch), .iterFail(iterFail),
    .atLimit(atLimit), .iterIdx(iterIndex)
  );

  otf_syn_control ctl (
    .clk(clk), .rst_n(rst_n), .cbStart(cbStart), .lastBatch(lastBatch),
    .iterFail(iterFail), .atLimit(atLimit), .ctrl(ctrl),
    .haltValid(haltValid), .nextIter(nextIter), .giveUpInvalid(giveUpInvalid),
    .verdictPass(verdictPass), .verdictReady(verdictReady), .busy(busy)
  );
endmodule

// File: tb/otf_syndrome_checker_test.sv
module otf_syndrome_checker_test;
  localparam int LANES = 4;
  localparam int ROWS = 32;
  localparam int BATCHES = ROWS / LANES;
  localparam int IW = 2;
  localparam int NVEC = 9;
  // vector: [8]=start, [7:4]=failing batch (15=none), [3:2]=lane, [1:0]=outcome
  // outcome codes: 1 halt, 2 next iteration, 3 give up
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 4'd15, 2'd0, 2'd1},  // R3 all even
    {1'b1, 4'd0,  2'd0, 2'd2},  // R2 first batch fails
    {1'b0, 4'd7,  2'd3, 2'd2},  // R5 last batch fails
    {1'b0, 4'd15, 2'd0, 2'd1},  // R6 clean after failures
    {1'b1, 4'd3,  2'd1, 2'd2},
    {1'b0, 4'd2,  2'd2, 2'd2},
    {1'b0, 4'd5,  2'd0, 2'd2},
    {1'b0, 4'd1,  2'd3, 2'd3},  // R7 limit
    {1'b1, 4'd15, 2'd0, 2'd1}
  };

  logic clk = 0, rst_n = 0, cbStart = 0;
  logic [LANES-1:0] rowDone = '0, rowParity = '0;
  logic haltValid, nextIter, giveUpInvalid, verdictPass, verdictReady, busy;
  logic [IW-1:0] iterIndex;
  int checks = 0, errors = 0;
  int expIter = 0;
  logic expPass = 0, expReady = 0;

  otf_syndrome_checker uut (
    .clk(clk), .rst_n(rst_n), .cbStart(cbStart), .rowDone(rowDone),
    .rowParity(rowParity), .haltValid(haltValid), .nextIter(nextIter),
    .giveUpInvalid(giveUpInvalid), .verdictPass(verdictPass),
    .verdictReady(verdictReady), .busy(busy), .iterIndex(iterIndex)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startCb();
    @(negedge clk); cbStart = 1;
    @(negedge clk); cbStart = 0;
    expIter = 0;
  endtask

  // drive one iteration of full batches; failure in batch fb on lane ln,
  // allLater makes every lane odd after the failing batch
  task automatic runIter(input int fb, input int ln, input bit allLater);
    for (int b = 0; b < BATCHES; b++) begin
      @(negedge clk);
      rowDone = '1;
      rowParity = '0;
      if (b == fb) rowParity[ln] = 1'b1;
      if (allLater && fb >= 0 && b > fb) rowParity = '1;
    end
    @(negedge clk);
    rowDone = '0; rowParity = '0;
  endtask

  task automatic checkOutcome(input int code, input string tag);
    int act;
    act = {30'd0, haltValid, 1'b0} | (nextIter ? 2 : 0) | (giveUpInvalid ? 3 : 0);
    act = haltValid ? 1 : nextIter ? 2 : giveUpInvalid ? 3 : 0;
    check(act == code && ({haltValid, nextIter, giveUpInvalid} != 3'b111),
          {tag, " outcome"}, act, code);
    if (code == 2) expIter++;
    if (code == 1) begin expPass = 1; expReady = 1; end
    if (code == 3) begin expPass = 0; expReady = 1; end
    check(verdictPass == expPass, {tag, " verdictPass"}, verdictPass, expPass);
    check(verdictReady == expReady, {tag, " verdictReady"}, verdictReady, expReady);
    check(iterIndex == IW'(expIter), "R8 iterIndex", iterIndex, expIter);
    @(negedge clk);
    check(!(haltValid | nextIter | giveUpInvalid), {tag, " single-cycle pulse R11"}, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!haltValid && !nextIter && !giveUpInvalid && !verdictPass && !verdictReady
          && !busy && iterIndex == 0, "R1 reset state", busy, 0);

    for (int v = 0; v < NVEC; v++) begin
      int fb;
      if (VEC[v][8]) startCb();
      fb = (VEC[v][7:4] == 4'd15) ? -1 : int'(VEC[v][7:4]);
      runIter(fb, int'(VEC[v][3:2]), 1'b0);
      checkOutcome(int'(VEC[v][1:0]), "R2/R3/R5/R6/R7 table");
    end

    // R4: early failure then every later row odd, then later rows even
    startCb();
    runIter(0, 2, 1'b1);
    checkOutcome(2, "R4 odd after first failure");
    runIter(1, 0, 1'b0);
    checkOutcome(2, "R4 even after first failure");
    runIter(-1, 0, 1'b0);
    checkOutcome(1, "R6 clean iteration");

    // R9: strobes while idle are ignored
    for (int b = 0; b < BATCHES; b++) begin
      @(negedge clk); rowDone = '1; rowParity = '1;
    end
    @(negedge clk); rowDone = '0; rowParity = '0;
    check(!haltValid && !nextIter && !giveUpInvalid, "R9 idle no pulse", 1, 0);
    check(verdictPass == 1 && verdictReady == 1 && !busy, "R9 verdict kept", verdictPass, 1);
    check(iterIndex == IW'(expIter), "R9 iterIndex kept", iterIndex, expIter);

    // R10: partial batches of two lanes; parity on unstrobed lanes ignored
    startCb();
    for (int b = 0; b < ROWS / 2; b++) begin
      @(negedge clk); rowDone = 4'b0011; rowParity = 4'b1100;
      if (b == ROWS / 2 - 2) begin
        @(negedge clk); rowDone = '0;
        check(!haltValid && !nextIter && busy, "R10 not done before last row", busy, 1);
      end
    end
    @(negedge clk); rowDone = '0; rowParity = '0;
    checkOutcome(1, "R10 partial batches");

    // R10: mixed lane counts 3+1 per pair of cycles, last single lane odd
    startCb();
    for (int b = 0; b < ROWS / 4; b++) begin
      @(negedge clk); rowDone = 4'b0111; rowParity = 4'b0000;
      @(negedge clk); rowDone = 4'b1000; rowParity = (b == ROWS / 4 - 1) ? 4'b1000 : 4'b0000;
    end
    @(negedge clk); rowDone = '0; rowParity = '0;
    checkOutcome(2, "R10 R5 mixed lanes last row odd");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule